// File: doc/BRIEF.md
# Two-Wire Register Slave with Staged Frequency Word

This block is a slave on a two-wire serial bus. Through it a host reads and writes a small file of 8-bit registers. SCL and SDA are sampled with a fast system clock. Each line passes a two-flop synchronizer and then an optional glitch filter. The slave tracks start and stop conditions, shifts bytes MSB first and drives SDA only through a pull-low enable. The board drives that enable onto an open-drain pad.

A transfer opens with the device byte. The next written byte sets the register pointer, and each later data byte goes to the pointer, which then advances by one. A read continues from the pointer last set. Four registers form a staged group that feeds a 32-bit frequency word. That word changes only when the last byte of the group is written.

The strap input has two jobs. It supplies one address bit. It also switches the glitch filter: strap low enables it, strap high bypasses it for faster buses.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges a device byte whose upper seven bits equal 110101 followed by the strap value. The byte is 0xD4/0xD5 with strap 0 and 0xD6/0xD7 with strap 1. It does not acknowledge any other device byte.
- R2: Bit 0 of the device byte selects direction: 0 is a host write and 1 is a host read. Bytes travel MSB first. The slave acknowledges by pulling SDA low during the ninth SCL pulse.
- R3: A stop condition (SDA rising while SCL is high) at any point returns the slave to idle. Bits clocked afterwards without a start are ignored. A start condition (SDA falling while SCL is high) at any point begins a fresh device byte.
- R4: The first written byte after the device byte selects the register. Each further data byte is stored at the pointer, and the pointer then advances by one. A read returns consecutive registers beginning at the pointer.
- R5: A register-select byte above the highest valid index (13) is not acknowledged. The slave returns to idle, and data bytes that follow are not acknowledged.
- R6: In a read that runs past register 13, the slave keeps sending register 13 until the host does not acknowledge.
- R7: After register 13 has been written in a transfer, a further data byte in the same transfer is not stored and is not acknowledged. The slave then returns to idle.
- R8: With strap 0, a pulse on SCL or SDA shorter than 50 ns is ignored. With strap 1 the filter is bypassed, and such a pulse counts as a clock edge.
- R9: Registers 8, 9, 10 and 11 form the frequency group, and the frequency output is {reg11, reg10, reg9, reg8}. The output changes only when register 11 is written. Writes to registers 8 to 10 leave it unchanged.
- R10: After reset all registers read 0, the frequency output is 0 and SDA is not pulled.
- R11: SDA is released while the slave is idle and during any byte slot the slave does not acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Address bit, and glitch filter disable when high |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad |
| sda_pull_o | output | 1 | High pulls SDA low |
| freq_o | output | 32 | Committed frequency word |

## Verification
The assertions watch the protocol engine on every cycle:
- a stop always lands in idle, and a start always reopens a device byte at bit zero;
- SDA is never pulled while the slave is idle;
- the pointer never leaves the valid range;
- a bad register-select byte, or a write past the top, ends in idle;
- the frequency word never moves without a write to register 11.

Only the bench scenarios show the rest, which is data seen at the pins over whole transfers:
- address matching under both strap values;
- data ordering under auto-increment;
- repetition of the top register on long reads;
- glitches absorbed or counted depending on the strap.

// File: rtl/i2c_reg_slave.sv
`timescale 1ns/1ps
module i2c_reg_slave #(
  parameter int CLK_NS   = 5,
  parameter int SPIKE_NS = 50,
  parameter int DEPTH    = 16,
  parameter int TOP_SUB  = 13,
  parameter int GRP_BASE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_i,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic [31:0] freq_o
);
  localparam int FILT_N = (SPIKE_NS + CLK_NS - 1) / CLK_NS;
  localparam int CW = $clog2(FILT_N + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] FMAX = CW'(FILT_N - 1);
  localparam logic [AW-1:0] TOPP = AW'(TOP_SUB);
  localparam logic [7:0]    TOP8 = 8'(TOP_SUB);
  localparam logic [AW-1:0] GRP3 = AW'(GRP_BASE + 3);

  typedef enum logic [2:0] {IDLE, RX, RX_ACK, TX, TX_ACK} st_t;

  logic [1:0] raw, s1, s2, filt;
  logic [CW-1:0] cnt [2];
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1[g] <= 1'b1; s2[g] <= 1'b1; filt[g] <= 1'b1; cnt[g] <= '0;
      end else begin
        s1[g] <= raw[g];
        s2[g] <= s1[g];
        if (strap_i) begin
          filt[g] <= s2[g]; cnt[g] <= '0;
        end else if (s2[g] == filt[g]) cnt[g] <= '0;
        else if (cnt[g] == FMAX) begin
          filt[g] <= s2[g]; cnt[g] <= '0;
        end else cnt[g] <= cnt[g] + 1'b1;
      end
  end

  logic scl, sda, scl_q, sda_q;
  assign scl = filt[1];
  assign sda = filt[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl; sda_q <= sda; end

  logic start_c, stop_c, rise, fall;
  assign start_c = scl & scl_q & sda_q & ~sda;
  assign stop_c  = scl & scl_q & ~sda_q & sda;
  assign rise    = scl & ~scl_q;
  assign fall    = ~scl & scl_q;

  st_t st;
  logic [7:0] mem [DEPTH];
  logic [7:0] sr;
  logic [3:0] bitcnt;
  logic [1:0] nbyte;
  logic [AW-1:0] ptr, nxt;
  logic ovf, go_tx, pull;
  logic [31:0] freq_q;

  logic byte_end, addr_hit, sub_ok, wr_en;
  assign byte_end = (st == RX) && fall && (bitcnt == 4'd8);
  assign addr_hit = sr[7:1] == {6'b110101, strap_i};
  assign sub_ok   = sr <= TOP8;
  assign wr_en    = byte_end && (nbyte == 2'd2) && !ovf;
  assign nxt      = (ptr == TOPP) ? ptr : ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; sr <= '0; bitcnt <= '0; nbyte <= '0; ptr <= '0;
      ovf <= 1'b0; go_tx <= 1'b0; pull <= 1'b0; freq_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (stop_c) begin
      st <= IDLE; pull <= 1'b0;
    end else if (start_c) begin
      st <= RX; bitcnt <= '0; nbyte <= '0; pull <= 1'b0; go_tx <= 1'b0;
    end else begin
      case (st)
        RX:
          if (rise) begin
            sr <= {sr[6:0], sda}; bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            st <= IDLE;
            case (nbyte)
              2'd0: if (addr_hit) begin
                st <= RX_ACK; pull <= 1'b1; go_tx <= sr[0]; nbyte <= 2'd1;
              end
              2'd1: if (sub_ok) begin
                st <= RX_ACK; pull <= 1'b1; ptr <= sr[AW-1:0]; ovf <= 1'b0; nbyte <= 2'd2;
              end
              default: if (!ovf) begin
                st <= RX_ACK; pull <= 1'b1; mem[ptr] <= sr; ptr <= nxt; ovf <= (ptr == TOPP);
                if (ptr == GRP3) freq_q <= {sr, mem[GRP_BASE+2], mem[GRP_BASE+1], mem[GRP_BASE]};
              end
            endcase
          end
        RX_ACK:
          if (fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              st <= TX; sr <= mem[ptr]; pull <= ~mem[ptr][7];
            end else begin
              st <= RX; pull <= 1'b0;
            end
          end
        TX:
          if (fall) begin
            if (bitcnt == 4'd7) begin
              st <= TX_ACK; pull <= 1'b0;
            end else begin
              sr <= {sr[6:0], 1'b0}; pull <= ~sr[6]; bitcnt <= bitcnt + 1'b1;
            end
          end
        TX_ACK:
          if (rise) begin
            if (sda) st <= IDLE;
            else begin st <= RX_ACK; ptr <= nxt; end
          end
        default: st <= IDLE;
      endcase
    end

  assign sda_pull_o = pull;
  assign freq_o = freq_q;

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> st == IDLE); // R3
  AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == RX && bitcnt == 4'd0 && nbyte == 2'd0)); // R3
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE |-> !sda_pull_o); // R11
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOPP); // R6
  AST_BAD_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && nbyte == 2'd1 && !sub_ok && !stop_c && !start_c) |=> (st == IDLE && !sda_pull_o)); // R5
  AST_NO_OVF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && nbyte == 2'd2 && ovf && !stop_c && !start_c) |=> (st == IDLE && !sda_pull_o)); // R7
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ptr == GRP3 && !stop_c && !start_c) |=> $stable(freq_o)); // R9
endmodule

// File: tb/tb_i2c_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_reg_slave;
  localparam int T = 100;
  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, scl = 1'b1, md = 1'b0;
  logic pull, sda_ln;
  logic [31:0] freq;
  int checks = 0, errors = 0;
  logic [7:0] wadr = 8'hD4;

  always #2.5 clk = ~clk;
  assign sda_ln = !(md | pull);

  i2c_reg_slave dut (.clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl),
                     .sda_i(sda_ln), .sda_pull_o(pull), .freq_o(freq));

  localparam logic [15:0] VEC [6] = '{16'h005A, 16'h0311, 16'h05C3,
                                       16'h07FF, 16'h0D80, 16'h0100};

  task automatic chk(input bit c, input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, a, e);
    end
  endtask

  task automatic st_c();
    md = 0; #T; scl = 1; #T; md = 1; #T; scl = 0; #T;
  endtask

  task automatic sp_c();
    md = 1; #T; scl = 1; #T; md = 0; #T;
  endtask

  task automatic wb(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (gl && i == 7) begin #(T/2); scl = 1; #20; scl = 0; #(T/2); end
      md = !b[i]; #T; scl = 1; #T; scl = 0; #T;
    end
    md = 0; #T; scl = 1; #(T/2); ack = !sda_ln; #(T/2); scl = 0; #T;
  endtask

  task automatic rb(input bit mack, output logic [7:0] b);
    md = 0;
    for (int i = 7; i >= 0; i--) begin
      #T; scl = 1; #(T/2); b[i] = sda_ln; #(T/2); scl = 0;
    end
    #T; md = mack; #T; scl = 1; #T; scl = 0; #T; md = 0;
  endtask

  task automatic wr(input logic [7:0] sub, input logic [31:0] d, input int n, output logic [5:0] acks);
    bit a;
    acks = '0;
    st_c();
    wb(wadr, 0, a); acks[0] = a;
    wb(sub, 0, a); acks[1] = a;
    for (int k = 0; k < n; k++) begin wb(d[8*k +: 8], 0, a); acks[2+k] = a; end
    sp_c();
  endtask

  task automatic rd(input logic [7:0] sub, input int n, output logic [31:0] q, output bit ok);
    bit a1, a2, a3;
    logic [7:0] b;
    q = '0;
    st_c(); wb(wadr, 0, a1); wb(sub, 0, a2);
    st_c(); wb(wadr | 8'h01, 0, a3);
    for (int k = 0; k < n; k++) begin rb(k != n - 1, b); q[8*k +: 8] = b; end
    sp_c();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] acks;
    logic [31:0] q;
    bit ok, a;
    repeat (10) @(posedge clk);
    #1;
    chk(pull == 1'b0, "R10 pull in reset", pull, 0);
    chk(freq == 32'h0, "R10 freq in reset", freq, 0);
    rst_n = 1; #(2*T);
    rd(8'h00, 1, q, ok);
    chk(ok && q == 32'h0, "R10 reg0 after reset", q, 0);

    for (int v = 0; v < 6; v++) begin
      wr(VEC[v][15:8], {24'h0, VEC[v][7:0]}, 1, acks);
      chk(acks[2:0] == 3'b111, "R2 single write acks", acks, 3'b111);
      rd(VEC[v][15:8], 1, q, ok);
      chk(ok && q[7:0] == VEC[v][7:0], "R4 single read back", q, VEC[v][7:0]);
    end

    wr(8'h00, 32'h00332211, 3, acks);
    chk(acks[4:0] == 5'b11111, "R4 burst write acks", acks, 5'b11111);
    rd(8'h00, 3, q, ok);
    chk(ok && q == 32'h00332211, "R4 burst read order", q, 32'h00332211);

    wr(8'h08, 32'h00CCBBAA, 3, acks);
    chk(freq == 32'h0, "R9 no commit before last byte", freq, 0);
    wr(8'h0B, 32'h000000DD, 1, acks);
    chk(freq == 32'hDDCCBBAA, "R9 commit on last byte", freq, 32'hDDCCBBAA);
    rd(8'h08, 4, q, ok);
    chk(ok && q == 32'hDDCCBBAA, "R9 staged bytes read", q, 32'hDDCCBBAA);

    wr(8'h0C, 32'h00003D5C, 2, acks);
    rd(8'h0C, 4, q, ok);
    chk(ok && q == 32'h3D3D3D5C, "R6 top register repeats", q, 32'h3D3D3D5C);

    st_c(); wb(wadr, 0, a); wb(8'h0D, 0, a); wb(8'h71, 0, a);
    chk(a == 1'b1, "R7 top write acked", a, 1);
    wb(8'h72, 0, a);
    chk(a == 1'b0, "R7 overflow byte nacked", a, 0);
    #1; chk(pull == 1'b0, "R11 released after nack", pull, 0);
    sp_c();
    rd(8'h0D, 1, q, ok);
    chk(ok && q[7:0] == 8'h71, "R7 overflow byte not stored", q, 8'h71);

    wr(8'h0E, 32'h00000055, 1, acks);
    chk(acks[2:0] == 3'b001, "R5 bad subaddress nacked", acks, 3'b001);
    chk(pull == 1'b0, "R11 released in idle", pull, 0);

    wadr = 8'hD6;
    wr(8'h00, 32'h000000EE, 1, acks);
    chk(acks[2:0] == 3'b000, "R1 wrong address ignored", acks, 0);
    wadr = 8'hD4;
    rd(8'h00, 1, q, ok);
    chk(ok && q[7:0] == 8'h11, "R1 reg0 untouched", q, 8'h11);

    st_c(); wb(wadr, 0, a); wb(8'h03, 0, a);
    for (int i = 7; i >= 4; i--) begin md = !(8'h77 >> i & 1); #T; scl = 1; #T; scl = 0; #T; end
    sp_c();
    a = 0;
    for (int i = 8; i >= 0; i--) begin
      md = (i == 0) ? 1'b0 : !(8'h55 >> (i - 1) & 1); #T; scl = 1; #(T/2);
      if (i == 0 && !sda_ln) a = 1;
      #(T/2); scl = 0; #T;
    end
    chk(a == 1'b0, "R3 no ack after stop", a, 0);
    rd(8'h03, 1, q, ok);
    chk(ok && q[7:0] == 8'h11, "R3 reg3 kept after stop", q, 8'h11);

    st_c(); wb(wadr, 0, a); wb(8'h05, 0, a);
    for (int i = 7; i >= 5; i--) begin md = 1'b0; #T; scl = 1; #T; scl = 0; #T; end
    st_c(); wb(wadr | 8'h01, 0, a);
    begin logic [7:0] b; rb(0, b); sp_c();
      chk(a && b == 8'hC3, "R3 restart mid byte", b, 8'hC3); end

    st_c(); wb(8'hD4, 1, a); chk(a == 1'b1, "R8 glitch filtered", a, 1);
    wb(8'h07, 0, a); wb(8'h42, 0, a); sp_c();
    rd(8'h07, 1, q, ok);
    chk(ok && q[7:0] == 8'h42, "R8 filtered write stored", q, 8'h42);
    strap = 1; wadr = 8'hD6; #(2*T);
    st_c(); wb(8'hD6, 1, a); sp_c();
    chk(a == 1'b0, "R8 glitch counted when bypassed", a, 0);
    wr(8'h07, 32'h00000024, 1, acks);
    chk(acks[2:0] == 3'b111, "R1 strap address acked", acks, 3'b111);
    rd(8'h07, 1, q, ok);
    chk(ok && q[7:0] == 8'h24, "R1 strap address read", q, 8'h24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule